// File: doc/BRIEF.md
# Spatial Dither Bit-Depth Reducer

This block takes a stream of 12-bit-per-component pixels (RGB or YCbCr, three channels) and reduces them to 10, 8 or 6 significant bits. Before the discarded bits are dropped, it adds pseudo-random noise. This spreads the quantisation error across the picture, so flat gradients do not show visible banding. The reduced value stays MSB-aligned in the 12-bit output word, and the dropped LSBs read as zero.

The noise comes from three 28-bit linear feedback shift registers, one per channel. They can share one feedback polynomial or use three distinct ones. The generators start from per-channel seeds. They can be reloaded at every frame start, and in that case a wrapping frame counter is bit-reversed and mixed into the seed so that successive frames get different patterns. An optional high-pass noise variant is available. A plain truncation path with its own depth code is used when dithering is off, and with both paths off the pixels pass through unchanged. Every path has a fixed latency of one clock.

Top module: `sdith_reducer`

## Requirements
- R1: The output is registered with a latency of exactly one clock. `outValid`, `outSof` and `outEol` follow `inValid`, `inSof` and `inEol` one cycle later, and `outValid` is 0 during and right after reset.
- R2: With `cfgDitherEn`=0 and `cfgTruncEn`=0, each output component equals its input component.
- R3: With `cfgDitherEn`=0 and `cfgTruncEn`=1, the output equals the input with its low bits zeroed. The number of zeroed bits follows `cfgTruncDepth`: code 0 zeroes 6 bits (6-bit result), code 1 zeroes 4 (8-bit), code 2 zeroes 2 (10-bit), and code 3 zeroes none.
- R4: With `cfgDitherEn`=1, the output is (input + noise) with its low D bits zeroed. D is taken from `cfgDepth` using the same code-to-width mapping as R3.
- R5: The dithered sum saturates at 4095 before the low bits are zeroed, so the output never wraps below the truncated input.
- R6: With `cfgPerChanPoly`=0, every channel advances as state' = {state[26:0], state[27]^state[2]} (polynomial x^28+x^3+1). The noise is the low D bits of the state in use for the current pixel.
- R7: With `cfgPerChanPoly`=1, the R, G and B generators feed back from state[2], state[8] and state[12] respectively (x^28+x^3+1, x^28+x^9+1, x^28+x^13+1).
- R8: The first valid pixel after reset, or after any cycle with `cfgDitherEn`=0, uses the channel seed as its state. A generator advances once per valid pixel while dithering and holds on cycles without a valid pixel.
- R9: With `cfgFrameRandom`=1, every valid pixel with `inSof`=1 uses seed XOR S as its state, where S is the frame counter bit-reversed. For depth codes 0 and 1, all 4 counter bits are reversed into seed bits [3:0] and the counter wraps after 15. For depth code 2, the low 2 counter bits are reversed into seed bits [1:0] and the counter wraps after 3. The counter starts at 0 when dithering is enabled and steps after each start-of-frame pixel.
- R10: With `cfgFrameRandom`=0, `inSof` does not reload the generators and the sequence continues across frames.
- R11: With `cfgHighPass`=1, the noise is state[D-1:0] XOR state[2D-1:D].
- R12: When `cfgDitherEn`=1, the dither path and `cfgDepth` apply, and `cfgTruncEn` and `cfgTruncDepth` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgDitherEn | input | 1 | Enable spatial dither |
| cfgDepth | input | 2 | Dither output depth code |
| cfgTruncEn | input | 1 | Enable truncate-only path |
| cfgTruncDepth | input | 2 | Truncate output depth code |
| cfgPerChanPoly | input | 1 | Distinct polynomial per channel |
| cfgFrameRandom | input | 1 | Reseed at each frame start |
| cfgHighPass | input | 1 | High-pass noise variant |
| cfgSeedR | input | 28 | Seed of the R/Cr generator |
| cfgSeedG | input | 28 | Seed of the G/Y generator |
| cfgSeedB | input | 28 | Seed of the B/Cb generator |
| inValid | input | 1 | Input pixel valid |
| inSof | input | 1 | Input start of frame |
| inEol | input | 1 | Input end of line |
| inR | input | 12 | Input R/Cr component |
| inG | input | 12 | Input G/Y component |
| inB | input | 12 | Input B/Cb component |
| outValid | output | 1 | Output pixel valid |
| outSof | output | 1 | Output start of frame |
| outEol | output | 1 | Output end of line |
| outR | output | 12 | Reduced R/Cr component |
| outG | output | 12 | Reduced G/Y component |
| outB | output | 12 | Reduced B/Cb component |

## Verification
The properties sample the configuration in the same cycle as the pixel that it governs. For that reason they assume all inputs are known (not X) whenever the clock rises after reset, and they do not depend on the configuration being stable. The stimulus changes the configuration only inside an idle cycle with dithering switched off. This matches the reload point of R8, so the model in the bench can restart its generators and frame counter at the same instant as the design. All seeds used are non-zero, so the generators never lock at the all-zero state.

// File: rtl/sdith_pkg.sv
`timescale 1ns/1ps
package sdith_pkg;
  localparam int PIX_W  = 12;
  localparam int LFSR_W = 28;
  localparam int N_CH   = 3;

  typedef struct packed {
    logic                         ditherOn;
    logic                         truncOn;
    logic [PIX_W-1:0]             keepMask;
    logic [N_CH-1:0][PIX_W-1:0]   noise;
  } dpCtrl_t;

  function automatic int dropWidth(input logic [1:0] code);
    case (code)
      2'd0:    return 6;
      2'd1:    return 4;
      2'd2:    return 2;
      default: return 0;
    endcase
  endfunction

  function automatic logic [PIX_W-1:0] lowMask(input logic [1:0] code);
    return PIX_W'((1 << dropWidth(code)) - 1);
  endfunction

  function automatic logic [LFSR_W-1:0] lfsrNext(input logic [LFSR_W-1:0] s, input int tap);
    return {s[LFSR_W-2:0], s[LFSR_W-1] ^ s[tap-1]};
  endfunction
endpackage

// File: rtl/sdith_ctrl.sv
`timescale 1ns/1ps
module sdith_ctrl
  import sdith_pkg::*;
#(
  parameter int FC_W = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          cfgDitherEn,
  input  logic [1:0]                    cfgDepth,
  input  logic                          cfgTruncEn,
  input  logic [1:0]                    cfgTruncDepth,
  input  logic                          cfgPerChanPoly,
  input  logic                          cfgFrameRandom,
  input  logic                          cfgHighPass,
  input  logic [N_CH-1:0][LFSR_W-1:0]   seeds,
  input  logic                          inValid,
  input  logic                          inSof,
  output dpCtrl_t                       ctrl
);
  logic             needLoad;
  logic [FC_W-1:0]  frameCnt;
  logic [FC_W-1:0]  frameLimit;
  logic [FC_W-1:0]  swapped;
  logic [1:0]       depthSel;
  logic [PIX_W-1:0] dropMask;
  int               dropW;
  logic             reseed, loadNow, stepEn;
  logic [PIX_W-1:0] noiseCh [N_CH];

  assign depthSel = cfgDitherEn ? cfgDepth : cfgTruncDepth;
  assign dropW    = dropWidth(depthSel);
  assign dropMask = lowMask(depthSel);
  assign reseed   = cfgFrameRandom & inSof;
  assign loadNow  = needLoad | reseed;
  assign stepEn   = cfgDitherEn & inValid;

  // wrap point and reversed counter for reseeding
  always_comb begin
    frameLimit = '0;
    swapped    = '0;
    if (cfgFrameRandom) begin
      if (cfgDepth == 2'd0 || cfgDepth == 2'd1) begin
        frameLimit = FC_W'(15);
        for (int i = 0; i < 4; i++) swapped[i] = frameCnt[3-i];
      end else if (cfgDepth == 2'd2) begin
        frameLimit = FC_W'(3);
        for (int i = 0; i < 2; i++) swapped[i] = frameCnt[1-i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !cfgDitherEn) begin
      needLoad <= 1'b1;
      frameCnt <= '0;
    end else if (stepEn) begin
      needLoad <= 1'b0;
      if (reseed) frameCnt <= (frameCnt == frameLimit) ? '0 : frameCnt + 1'b1;
    end
  end

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
    localparam int OWN_TAP = (ch == 0) ? 3 : (ch == 1) ? 9 : 13;
    logic [LFSR_W-1:0] state, seedMix, src;
    logic [PIX_W-1:0]  srcLow, hpPart;
    int                tap;

    assign tap     = cfgPerChanPoly ? OWN_TAP : 3;
    assign seedMix = seeds[ch] ^ LFSR_W'(swapped);
    assign src     = loadNow ? seedMix : state;
    assign srcLow  = src[PIX_W-1:0];
    assign hpPart  = cfgHighPass ? ((srcLow >> dropW) & dropMask) : '0;
    assign noiseCh[ch] = (srcLow & dropMask) ^ hpPart;

    always_ff @(posedge clk) begin
      if (!rstN)       state <= '0;
      else if (stepEn) state <= lfsrNext(src, tap);
    end
  end

  always_comb begin
    ctrl.ditherOn = cfgDitherEn;
    ctrl.truncOn  = cfgTruncEn & ~cfgDitherEn;
    ctrl.keepMask = ~dropMask;
    for (int c = 0; c < N_CH; c++) ctrl.noise[c] = noiseCh[c];
  end
endmodule

// File: rtl/sdith_datapath.sv
`timescale 1ns/1ps
module sdith_datapath
  import sdith_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  dpCtrl_t                     ctrl,
  input  logic                        inValid,
  input  logic                        inSof,
  input  logic                        inEol,
  input  logic [N_CH-1:0][PIX_W-1:0]  pixIn,
  output logic                        outValid,
  output logic                        outSof,
  output logic                        outEol,
  output logic [N_CH-1:0][PIX_W-1:0]  pixOut
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outSof   <= 1'b0;
      outEol   <= 1'b0;
    end else begin
      outValid <= inValid;
      outSof   <= inValid & inSof;
      outEol   <= inValid & inEol;
    end
  end

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_lane
    logic [PIX_W:0]   sum;
    logic [PIX_W-1:0] sat, reduced;
    assign sum = {1'b0, pixIn[ch]} + {1'b0, ctrl.noise[ch]};
    assign sat = sum[PIX_W] ? '1 : sum[PIX_W-1:0];
    always_comb begin
      if (ctrl.ditherOn)     reduced = sat & ctrl.keepMask;
      else if (ctrl.truncOn) reduced = pixIn[ch] & ctrl.keepMask;
      else                   reduced = pixIn[ch];
    end
    always_ff @(posedge clk) begin
      if (!rstN)        pixOut[ch] <= '0;
      else if (inValid) pixOut[ch] <= reduced;
    end
  end
endmodule

// File: rtl/sdith_reducer.sv
`timescale 1ns/1ps
module sdith_reducer
  import sdith_pkg::*;
#(
  parameter int FC_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgDitherEn,
  input  logic [1:0]        cfgDepth,
  input  logic              cfgTruncEn,
  input  logic [1:0]        cfgTruncDepth,
  input  logic              cfgPerChanPoly,
  input  logic              cfgFrameRandom,
  input  logic              cfgHighPass,
  input  logic [LFSR_W-1:0] cfgSeedR,
  input  logic [LFSR_W-1:0] cfgSeedG,
  input  logic [LFSR_W-1:0] cfgSeedB,
  input  logic              inValid,
  input  logic              inSof,
  input  logic              inEol,
  input  logic [PIX_W-1:0]  inR,
  input  logic [PIX_W-1:0]  inG,
  input  logic [PIX_W-1:0]  inB,
  output logic              outValid,
  output logic              outSof,
  output logic              outEol,
  output logic [PIX_W-1:0]  outR,
  output logic [PIX_W-1:0]  outG,
  output logic [PIX_W-1:0]  outB
);
  dpCtrl_t                      ctrl;
  logic [N_CH-1:0][PIX_W-1:0]   pixOut;

  sdith_ctrl #(.FC_W(FC_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgDitherEn(cfgDitherEn), .cfgDepth(cfgDepth),
    .cfgTruncEn(cfgTruncEn), .cfgTruncDepth(cfgTruncDepth),
    .cfgPerChanPoly(cfgPerChanPoly), .cfgFrameRandom(cfgFrameRandom),
    .cfgHighPass(cfgHighPass), .seeds({cfgSeedB, cfgSeedG, cfgSeedR}),
    .inValid(inValid), .inSof(inSof), .ctrl(ctrl)
  );

  sdith_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .inValid(inValid), .inSof(inSof), .inEol(inEol),
    .pixIn({inB, inG, inR}),
    .outValid(outValid), .outSof(outSof), .outEol(outEol),
    .pixOut(pixOut)
  );

  assign outR = pixOut[0];
  assign outG = pixOut[1];
  assign outB = pixOut[2];
endmodule

// File: rtl/sdith_checker.sv
`timescale 1ns/1ps
module sdith_checker (
  input logic        clk,
  input logic        rstN,
  input logic        cfgDitherEn,
  input logic [1:0]  cfgDepth,
  input logic        cfgTruncEn,
  input logic [1:0]  cfgTruncDepth,
  input logic        inValid,
  input logic        inSof,
  input logic        inEol,
  input logic [11:0] inR,
  input logic [11:0] inG,
  input logic        outValid,
  input logic        outSof,
  input logic        outEol,
  input logic [11:0] outR,
  input logic [11:0] outG
);
  function automatic logic [11:0] maskOf(input logic [1:0] c);
    case (c)
      2'd0:    return 12'h03F;
      2'd1:    return 12'h00F;
      2'd2:    return 12'h003;
      default: return 12'h000;
    endcase
  endfunction

  p_valid_lat_r1: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  p_idle_lat_r1: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  p_marks_r1: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (outSof == $past(inSof) && outEol == $past(inEol)));
  p_bypass_r2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !cfgDitherEn && !cfgTruncEn) |=> (outR == $past(inR) && outG == $past(inG)));
  p_trunc_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !cfgDitherEn && cfgTruncEn) |=>
      ((outR & maskOf($past(cfgTruncDepth))) == 12'h000));
  p_dither_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && cfgDitherEn) |=> ((outG & maskOf($past(cfgDepth))) == 12'h000));
  p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && cfgDitherEn) |=> (outR >= ($past(inR) & ~maskOf($past(cfgDepth)))));
endmodule

bind sdith_reducer sdith_checker u_chk (.*);

// File: tb/sdith_reducer_tb.sv
`timescale 1ns/1ps
module sdith_reducer_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgDitherEn = 0, cfgTruncEn = 0, cfgPerChanPoly = 0, cfgFrameRandom = 0, cfgHighPass = 0;
  logic [1:0]  cfgDepth = 0, cfgTruncDepth = 0;
  logic [27:0] cfgSeedR = 28'h0000001, cfgSeedG = 28'h0000001, cfgSeedB = 28'h0000001;
  logic        inValid = 0, inSof = 0, inEol = 0;
  logic [11:0] inR = 0, inG = 0, inB = 0;
  logic        outValid, outSof, outEol;
  logic [11:0] outR, outG, outB;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [27:0] mL [3];
  bit          mNeed = 1;
  int          mFc = 0;

  always #4 clk = ~clk;

  sdith_reducer u_dut (.*);

  function automatic int dw(input logic [1:0] c);
    return (c == 0) ? 6 : (c == 1) ? 4 : (c == 2) ? 2 : 0;
  endfunction

  function automatic logic [27:0] seedOf(input int ch);
    return (ch == 0) ? cfgSeedR : (ch == 1) ? cfgSeedG : cfgSeedB;
  endfunction

  function automatic int tapOf(input int ch);
    if (!cfgPerChanPoly) return 3;
    return (ch == 0) ? 3 : (ch == 1) ? 9 : 13;
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input string req);
    @(negedge clk);
    inValid = 0; inSof = 0; inEol = 0;
    @(posedge clk); #1;
    if (!cfgDitherEn) begin mNeed = 1; mFc = 0; end
    check(outValid == 1'b0, req, "outValid idle", outValid, 0);
  endtask

  task automatic pix(input bit sof, input bit eol, input logic [11:0] r, input logic [11:0] g,
                     input logic [11:0] b, input string req);
    logic [11:0] pin [3];
    logic [11:0] exp [3];
    logic [11:0] act [3];
    pin[0] = r; pin[1] = g; pin[2] = b;
    if (cfgDitherEn) begin
      int d = dw(cfgDepth);
      int m = (1 << d) - 1;
      int lim = 0, sw = 0;
      bit load = mNeed || (cfgFrameRandom && sof);
      if (cfgFrameRandom && cfgDepth <= 1) begin
        lim = 15;
        sw = ((mFc & 1) << 3) | ((mFc & 2) << 1) | ((mFc & 4) >> 1) | ((mFc & 8) >> 3);
      end else if (cfgFrameRandom && cfgDepth == 2) begin
        lim = 3;
        sw = ((mFc & 1) << 1) | ((mFc & 2) >> 1);
      end
      for (int ch = 0; ch < 3; ch++) begin
        logic [27:0] src = load ? (seedOf(ch) ^ 28'(sw)) : mL[ch];
        int n = int'(src[11:0]) & m;
        int s;
        if (cfgHighPass) n = n ^ ((int'(src[11:0]) >> d) & m);
        s = int'(pin[ch]) + n;
        if (s > 4095) s = 4095;
        exp[ch] = 12'(s & ~m);
        mL[ch] = {src[26:0], src[27] ^ src[tapOf(ch)-1]};
      end
      if (cfgFrameRandom && sof) mFc = (mFc == lim) ? 0 : mFc + 1;
      mNeed = 0;
    end else begin
      for (int ch = 0; ch < 3; ch++)
        exp[ch] = cfgTruncEn ? (pin[ch] & ~12'((1 << dw(cfgTruncDepth)) - 1)) : pin[ch];
    end
    @(negedge clk);
    inValid = 1; inSof = sof; inEol = eol; inR = r; inG = g; inB = b;
    @(posedge clk); #1;
    act[0] = outR; act[1] = outG; act[2] = outB;
    check(outValid && outSof == sof && outEol == eol, "R1", "markers",
          {outValid, outSof, outEol}, {1'b1, sof, eol});
    for (int ch = 0; ch < 3; ch++)
      check(act[ch] == exp[ch], req, $sformatf("ch%0d", ch), act[ch], exp[ch]);
  endtask

  // configuration changes always pass through an idle, dither-off cycle
  task automatic setCfg(input bit de, input logic [1:0] dep, input bit te, input logic [1:0] td,
                        input bit pc, input bit fr, input bit hp);
    @(negedge clk);
    cfgDitherEn = 0;
    idle("R8");
    @(negedge clk);
    cfgDitherEn = de; cfgDepth = dep; cfgTruncEn = te; cfgTruncDepth = td;
    cfgPerChanPoly = pc; cfgFrameRandom = fr; cfgHighPass = hp;
  endtask

  task automatic stream(input int n, input int sofEvery, input int gapEvery, input string req);
    for (int i = 0; i < n; i++) begin
      logic [11:0] r = 12'((i * 37 + 5) % 4096);
      logic [11:0] g = 12'((i * 101 + 1000) % 4096);
      logic [11:0] b = 12'((i * 611 + 4000) % 4096);
      pix((i % sofEvery) == 0, (i % 8) == 7, r, g, b, req);
      if (gapEvery > 0 && (i % gapEvery) == gapEvery - 1) idle("R8");
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(outValid == 0, "R1", "reset outValid", outValid, 0);
    @(negedge clk); rstN = 1;
    idle("R1");

    // R2 bypass sweep
    for (int i = 0; i < 64; i++)
      pix(i == 0, 0, 12'(i * 64 + 63), 12'(4095 - i * 61), 12'(i * 17), "R2");

    // R3 truncate sweep over all depth codes
    for (int d = 0; d < 4; d++) begin
      setCfg(0, 0, 1, 2'(d), 0, 0, 0);
      for (int i = 0; i < 64; i++)
        pix(0, 0, 12'(i * 67 + d), 12'(i * 64 + 63), 12'(4095 - i), "R3");
    end

    cfgSeedR = 28'hA5C3E17; cfgSeedG = 28'h13579BD; cfgSeedB = 28'hFEDCBA9;
    // R4 R6 R8 shared polynomial, all depths, with gaps
    for (int d = 0; d < 3; d++) begin
      setCfg(1, 2'(d), 0, 0, 0, 0, 0);
      stream(150, 1000, 7, "R6");
    end
    // R7 per-channel taps
    for (int d = 0; d < 3; d++) begin
      setCfg(1, 2'(d), 0, 0, 1, 0, 0);
      stream(150, 1000, 0, "R7");
    end
    // R5 saturation near full scale
    setCfg(1, 0, 0, 0, 1, 0, 0);
    for (int i = 0; i < 40; i++)
      pix(0, 0, 12'hFFF, 12'(4090 + (i % 6)), 12'hFC1, "R5");
    // R9 frame reseed with counter wrap, depths 0 and 2
    setCfg(1, 0, 0, 0, 0, 1, 0);
    stream(20 * 3, 3, 0, "R9");
    setCfg(1, 2, 0, 0, 1, 1, 0);
    stream(10 * 3, 3, 0, "R9");
    // R10 frame starts without reseed
    setCfg(1, 1, 0, 0, 1, 0, 0);
    stream(60, 4, 0, "R10");
    // R11 high-pass noise
    for (int d = 0; d < 3; d++) begin
      setCfg(1, 2'(d), 0, 0, 1, 0, 1);
      stream(80, 1000, 5, "R11");
    end
    // R12 dither takes precedence over truncate
    setCfg(1, 2, 1, 0, 0, 0, 0);
    stream(40, 1000, 0, "R12");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule